// File: doc/BRIEF.md
# Disk Geometry Calculator (Sector Count to Cylinders, Heads, Sectors)

This block turns a disk capacity, given as a count of logical sectors, into the default cylinder, head and sectors-per-track triple that a drive reports as its legacy geometry. A start strobe launches one computation. The block picks sectors-per-track and heads with clamping rules, then finds the cylinder count by dividing the capacity by the track-times-head product. Both divisions run one after the other on a single bit-serial restoring divider.

The caller pulses `start` for one cycle while the block is idle and then waits for `done`. All three outputs are written on the edge that raises `done`, and they keep their values until the next result. Two cases finish without any division. A capacity of zero gives all-zero outputs. A capacity at or above the saturation point gives the clamped maximum geometry.

Top module: `chs_geom_calc`

## Requirements
- R1: While and after reset, and until the first result, `cyl`, `heads`, `spt`, `busy` and `done` are all zero.
- R2: A capacity of at least 16,514,064 sectors (16383 × 16 × 63) yields cyl = 16383, heads = 16 and spt = 63.
- R3: Below saturation, spt equals 63 when the capacity is 63 or more, and equals the capacity itself when the capacity is from 1 to 62.
- R4: Below saturation, heads equals the truncated quotient capacity / spt when that quotient is under 16, and 16 otherwise.
- R5: Below saturation, cyl equals the truncated quotient capacity / (heads × spt).
- R6: A capacity of zero yields cyl = 0, heads = 0 and spt = 0, and `done` is still raised.
- R7: `done` is high for exactly one cycle per accepted start. It rises on the same edge that writes the outputs, and the outputs do not change in any cycle where `done` is low.
- R8: `busy` is high from the cycle after an accepted start that needs division until the cycle `done` rises. A `start` that arrives while `busy` is high is ignored, so it does not change the result that is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle strobe that launches a computation when the block is idle |
| capacity | input | 32 | Disk size in sectors, sampled with `start` |
| busy | output | 1 | A division-based computation is in progress |
| done | output | 1 | One-cycle pulse: outputs now hold a new result |
| cyl | output | 16 | Derived cylinder count |
| heads | output | 8 | Derived head count |
| spt | output | 8 | Derived sectors per track |

## Verification
Suppose a stale divisor, a wrong clamp or a mis-sequenced state reaches the outputs. It appears at the next `done` as a field that differs from the arithmetic reference, about 70 cycles after start for a divided case and one cycle after start for a zero or saturated one. A sequencing error that loses `done` stops the result stream altogether, and an extra pulse appears as an unmatched result. The capacities chosen for the checks sit on every clamp boundary (0, 1, 62, 63, 1008, 1009, just below and at saturation) so that an off-by-one in a comparison changes some field. Overlapping starts and the hold window after `done` show whether a result can be disturbed.

// File: rtl/chs_geom_pkg.sv
// Package: shared types for the geometry calculator.
// Assumes: one controller uses the state encoding below.
package chs_geom_pkg;

    // Sequencer states of the geometry controller
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD1 = 3'd1,
        ST_WAIT1 = 3'd2,
        ST_LOAD2 = 3'd3,
        ST_WAIT2 = 3'd4
    } geo_state_t;

endpackage

// File: rtl/geo_limit.sv
// Module: geo_limit
// Passes its input through, but clamps it to the ceiling LIM.
// Assumes: LIM fits in W bits. Purely combinational.
module geo_limit #(
    parameter int          W   = 32,
    parameter logic [W-1:0] LIM = W'(63)
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] val_o
);

    // Clamp the input to the ceiling
    always_comb begin
        val_o = (val_i > LIM) ? LIM : val_i;
    end

endmodule

// File: rtl/geo_div.sv
// Module: geo_div
// Unsigned restoring divider that retires one quotient bit per clock.
// When start is seen it latches dividend and divisor. After W cycles it
// presents the quotient and pulses done_o for one cycle.
// Assumes: the divisor is never zero, and start is only given while idle.
module geo_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quotient_o,
    output logic         done_o
);

    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q;
    logic [W-1:0]     quo_q;
    logic [W-1:0]     dvs_q;
    logic [W-1:0]     dvd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             done_q;
    logic [W:0]       shifted;
    logic             fits;
    logic [2*W-1:0]   recon;

    // Shift the next dividend bit in and trial-subtract the divisor
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        fits    = (shifted >= {1'b0, dvs_q});
    end

    // Iteration register: load on start, one bit per cycle while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            dvd_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !run_q) begin
                rem_q <= '0;
                quo_q <= dividend_i;
                dvd_q <= dividend_i;
                dvs_q <= divisor_i;
                cnt_q <= CNT_W'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (fits) begin
                    rem_q <= W'(shifted - {1'b0, dvs_q});
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign quotient_o = quo_q;
    assign done_o     = done_q;

    // Reconstruct the dividend from the result, for checking only
    always_comb begin
        recon = ({{W{1'b0}}, quo_q} * {{W{1'b0}}, dvs_q}) + {{W{1'b0}}, rem_q};
    end

    // R5
    div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !run_q) |-> (divisor_i != '0));

    // R5
    div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ((recon == {{W{1'b0}}, dvd_q}) && (rem_q < dvs_q)));

    // R7
    div_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/chs_geom_calc.sv
// Module: chs_geom_calc (top)
// Derives default cylinders, heads and sectors-per-track from a sector
// count. It clamps sectors-per-track and heads, then runs two divisions in
// sequence on one shared serial divider.
// Assumes: start comes only as a strobe; a start seen while busy is dropped.
module chs_geom_calc #(
    parameter int CAP_W     = 32,
    parameter int CYL_W     = 16,
    parameter int HD_W      = 8,
    parameter int SPT_W     = 8,
    parameter int MAX_CYL   = 16383,
    parameter int MAX_HEADS = 16,
    parameter int MAX_SPT   = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CAP_W-1:0] capacity,
    output logic             busy,
    output logic             done,
    output logic [CYL_W-1:0] cyl,
    output logic [HD_W-1:0]  heads,
    output logic [SPT_W-1:0] spt
);
    import chs_geom_pkg::*;

    localparam int               PROD_W  = HD_W + SPT_W;
    localparam logic [CAP_W-1:0] SAT_CAP = CAP_W'(MAX_CYL * MAX_HEADS * MAX_SPT);

    geo_state_t        state_q;
    logic [CAP_W-1:0]  cap_q;
    logic [HD_W-1:0]   heads_q;
    logic [SPT_W-1:0]  spt_q;
    logic [CYL_W-1:0]  cyl_o_q;
    logic [HD_W-1:0]   heads_o_q;
    logic [SPT_W-1:0]  spt_o_q;
    logic              done_q;

    logic [CAP_W-1:0]  spt_lim;
    logic [CAP_W-1:0]  heads_lim;
    logic [PROD_W-1:0] track_prod;
    logic              div_start;
    logic [CAP_W-1:0]  div_dvs;
    logic [CAP_W-1:0]  div_quo;
    logic              div_done;

    // Sectors-per-track: the capacity clamped to the track limit
    geo_limit #(.W(CAP_W), .LIM(CAP_W'(MAX_SPT))) u_spt_lim (
        .val_i (cap_q),
        .val_o (spt_lim)
    );

    // Heads: the first quotient clamped to the head limit
    geo_limit #(.W(CAP_W), .LIM(CAP_W'(MAX_HEADS))) u_hd_lim (
        .val_i (div_quo),
        .val_o (heads_lim)
    );

    // Divider operand selection for the two division passes
    always_comb begin
        track_prod = {{SPT_W{1'b0}}, heads_q} * {{HD_W{1'b0}}, spt_q};
        div_start  = (state_q == ST_LOAD1) || (state_q == ST_LOAD2);
        div_dvs    = (state_q == ST_LOAD1) ? spt_lim : CAP_W'(track_prod);
    end

    geo_div #(.W(CAP_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .dividend_i (cap_q),
        .divisor_i  (div_dvs),
        .quotient_o (div_quo),
        .done_o     (div_done)
    );

    // Sequencer: accept start, handle the shortcut cases, run both divisions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cap_q     <= '0;
            heads_q   <= '0;
            spt_q     <= '0;
            cyl_o_q   <= '0;
            heads_o_q <= '0;
            spt_o_q   <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cap_q <= capacity;
                        if (capacity == '0) begin
                            cyl_o_q   <= '0;
                            heads_o_q <= '0;
                            spt_o_q   <= '0;
                            done_q    <= 1'b1;
                        end else if (capacity >= SAT_CAP) begin
                            cyl_o_q   <= CYL_W'(MAX_CYL);
                            heads_o_q <= HD_W'(MAX_HEADS);
                            spt_o_q   <= SPT_W'(MAX_SPT);
                            done_q    <= 1'b1;
                        end else begin
                            state_q <= ST_LOAD1;
                        end
                    end
                end
                ST_LOAD1: begin
                    spt_q   <= spt_lim[SPT_W-1:0];
                    state_q <= ST_WAIT1;
                end
                ST_WAIT1: begin
                    if (div_done) begin
                        heads_q <= heads_lim[HD_W-1:0];
                        state_q <= ST_LOAD2;
                    end
                end
                ST_LOAD2: begin
                    state_q <= ST_WAIT2;
                end
                ST_WAIT2: begin
                    if (div_done) begin
                        cyl_o_q   <= div_quo[CYL_W-1:0];
                        heads_o_q <= heads_q;
                        spt_o_q   <= spt_q;
                        done_q    <= 1'b1;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy  = (state_q != ST_IDLE);
    assign done  = done_q;
    assign cyl   = cyl_o_q;
    assign heads = heads_o_q;
    assign spt   = spt_o_q;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(cyl) && $stable(heads) && $stable(spt)));

    // R8
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (capacity != '0) && (capacity < SAT_CAP)) |=> busy);

    // R2
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cap_q >= SAT_CAP)) |->
        ((cyl == CYL_W'(MAX_CYL)) && (heads == HD_W'(MAX_HEADS)) && (spt == SPT_W'(MAX_SPT))));

    // R6
    zero_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cap_q == '0)) |-> ((cyl == '0) && (heads == '0) && (spt == '0)));

    // R3
    spt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spt <= SPT_W'(MAX_SPT)));

    // R4
    heads_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (heads <= HD_W'(MAX_HEADS)));

    // R5
    cyl_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_done && (state_q == ST_WAIT2)) |-> (div_quo <= CAP_W'(MAX_CYL)));

endmodule

// File: tb/sim_chs_geom_calc.sv
module sim_chs_geom_calc;

    typedef struct {
        logic [31:0] cap;
        logic [15:0] cyl;
        logic [7:0]  hd;
        logic [7:0]  sp;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] capacity = '0;
    logic        busy, done;
    logic [15:0] cyl;
    logic [7:0]  heads, spt;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t sb[$];
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    chs_geom_calc u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .capacity(capacity),
        .busy(busy), .done(done), .cyl(cyl), .heads(heads), .spt(spt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // Reference geometry from the requirements
    function automatic exp_t model(input logic [31:0] c);
        exp_t e;
        longint s, q, h;
        e.cap = c;
        if (c == 0) begin
            e.cyl = 0; e.hd = 0; e.sp = 0;
        end else if (c >= 32'd16514064) begin
            e.cyl = 16383; e.hd = 16; e.sp = 63;
        end else begin
            s = (c < 63) ? c : 63;
            q = c / s;
            h = (q >= 16) ? 16 : q;
            e.sp  = 8'(s);
            e.hd  = 8'(h);
            e.cyl = 16'(c / (h * s));
        end
        return e;
    endfunction

    task automatic run_case(input logic [31:0] c);
        sb.push_back(model(c));
        @(negedge clk);
        start = 1'b1; capacity = c;
        @(negedge clk);
        start = 1'b0;
        wait (sb.size() == 0);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pop an expectation at each done, then check the hold window
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb.size() == 0) begin
                    check("R7 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check("R3 spt", 32'(spt), 32'(e.sp));
                    check("R4 heads", 32'(heads), 32'(e.hd));
                    check("R5 cyl", 32'(cyl), 32'(e.cyl));
                    if (e.cap == 0) check("R6 zero cyl", 32'(cyl), 0);
                    if (e.cap >= 32'd16514064) check("R2 saturated cyl", 32'(cyl), 16383);
                    check("R8 busy low at done", 32'(busy), 0);
                    @(negedge clk);
                    check("R7 done one cycle", 32'(done), 0);
                    check("R7 cyl held", 32'(cyl), 32'(e.cyl));
                    check("R7 heads held", 32'(heads), 32'(e.hd));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Driver
    initial begin
        repeat (4) @(negedge clk);
        check("R1 cyl in reset", 32'(cyl), 0);
        check("R1 done in reset", 32'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cyl", 32'(cyl), 0);
        check("R1 heads", 32'(heads), 0);
        check("R1 spt", 32'(spt), 0);
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);

        run_case(32'd0);          // R6
        run_case(32'd1);          // R3 small disk
        run_case(32'd62);         // R3
        run_case(32'd63);         // R3 boundary
        run_case(32'd100);
        run_case(32'd1000);       // R4 quotient under 16
        run_case(32'd1008);       // R4 boundary
        run_case(32'd1009);
        run_case(32'd500000);     // R5
        run_case(32'd16514063);   // R2 just below
        run_case(32'd16514064);   // R2 boundary
        run_case(32'hFFFF_FFFF);  // R2

        // R8: busy rises, and a second start while busy is ignored
        sb.push_back(model(32'd777777));
        @(negedge clk);
        start = 1'b1; capacity = 32'd777777;
        @(negedge clk);
        start = 1'b0;
        check("R8 busy after start", 32'(busy), 1);
        repeat (5) @(negedge clk);
        start = 1'b1; capacity = 32'd5;
        @(negedge clk);
        start = 1'b0;
        wait (sb.size() == 0);
        repeat (80) @(negedge clk);
        check("R8 no extra result", 32'(sb.size()), 0);
        check("R8 idle after ignored start", 32'(busy), 0);
        check("R8 result kept", 32'(cyl), 32'(model(32'd777777).cyl));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule